// File: doc/BRIEF.md
# Bus Chip-Select Channel with Wait-State Acknowledge

This block is one chip-select channel for an external bus. Software loads two 16-bit words through a small write port: a base word holding the upper address bits to decode, and an option word setting the address space, transfer direction, byte lane, interrupt level, strobe choice, timing mode and acknowledge timing. On every bus access the channel compares the live bus signals against these fields. On a match it drives an active-low select to the external device. It can also end the bus cycle itself by returning an active-low acknowledge after a programmed number of wait states.

Option word layout (bit positions): `[15]` sync mode, `[14:13]` lane, `[12:11]` direction, `[10]` strobe select (0 = address strobe, 1 = data strobe), `[9:6]` acknowledge code, `[5:4]` space, `[3:1]` level, `[0]` autovector enable. The base word holds the compared address bits in its upper `BASE_W` bits (`cfg_wdata[15 -: BASE_W]`). Writing with `cfg_sel`=0 loads the base word and with `cfg_sel`=1 loads the option word.

A small state machine sequences each access. The states are:
- IDLE: waits for a strobe.
- SYNC: waits for the E-clock enable.
- WAIT: counts wait states.
- ACK: select and acknowledge are driven.
- EXT: select is driven and the external device acknowledges.
- MISS: the access did not match.

The transitions are:
- IDLE to MISS when the strobe arrives without a match.
- IDLE to SYNC on a match in sync mode while the enable is low.
- IDLE or SYNC to the launch target when the access is launched.
- WAIT to ACK when the count reaches one.
- Any state to IDLE while the address strobe is negated.

The launch target is ACK for code 0 or 14, WAIT for codes 1 to 13, and EXT for code 15.

Top module: `csel_channel`

## Requirements
- R1: While `rst_n` is low, `cs_n` and `int_ack_n` are high and `avec_req` is low. After reset both configuration words are zero, and direction 00 never matches, so no access selects.
- R2: Outside CPU space, a match needs `bus_addr[ADDR_W-1 -: BASE_W]` to equal the base field.
- R3: Space field: 01 = user (fc 1, 2), 10 = supervisor (fc 5, 6), 11 = either. Other function codes never match these settings.
- R4: Space 00 matches only fc 7 (interrupt acknowledge). In that space the base compare is skipped, and `bus_addr[3:1]` must equal the level field unless the level field is 000, which matches any level.
- R5: Direction field: 00 = never, 01 = reads only (`bus_rw`=1), 10 = writes only, 11 = both.
- R6: Lane field: 00 = never, 10 = upper lane, 01 = lower lane, 11 = both. A byte access (`bus_siz`=01) touches the upper lane at even addresses and the lower lane at odd ones; any other size touches both lanes.
- R7: In async mode, `cs_n` falls in the same cycle as the selected strobe (AS, or DS when strobe select is 1) with the match present.
- R8: In sync mode, `cs_n` falls in the cycle after the first cycle in which the strobe, the match and `eclk_en` are all present.
- R9: For acknowledge code N in 0..13, `int_ack_n` falls N+1 cycles after the launch cycle and stays low until AS negates.
- R10: Code 14 gives fast termination: the acknowledge comes with the select (async: same cycle as the strobe). Code 15 never drives `int_ack_n`, while the select stays low until AS negates.
- R11: Negating `bus_as_n` raises `cs_n` and `int_ack_n` in the same cycle. The wait count restarts on each new access.
- R12: `avec_req` is high only while `cs_n` is low during a fc 7 access with the autovector bit set and `irq_pin_ack` high.
- R13: `int_ack_n` is never low while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = base word, 1 = option word |
| cfg_wdata | input | 16 | Configuration write data |
| bus_addr | input | ADDR_W | Bus address |
| bus_fc | input | 3 | Function code |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_siz | input | 2 | Transfer size, 01 = byte |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds_n | input | 1 | Data strobe, active low |
| eclk_en | input | 1 | E-clock alignment enable |
| irq_pin_ack | input | 1 | Acknowledged level came from a dedicated interrupt pin |
| cs_n | output | 1 | Chip select, active low |
| int_ack_n | output | 1 | Internal acknowledge, active low |
| avec_req | output | 1 | Autovector request |

## Verification
The bench builds the block with its defaults: a 24-bit address, a 13-bit base field and a 16-bit port. With these values the lane decode is present, so odd and even byte accesses and multi-byte sizes all reach distinct lane outcomes. The interrupt-level field also sits clear of the base-compared bits. The full 4-bit acknowledge code is reachable, including the longest count of 13 waits, fast termination and external acknowledge.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int ACK_W = 4;
    localparam logic [ACK_W-1:0] ACK_FAST = 4'd14;
    localparam logic [ACK_W-1:0] ACK_EXT  = 4'd15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_WAIT,
        ST_ACK,
        ST_EXT,
        ST_MISS
    } cs_state_e;

    typedef struct packed {
        logic             sync_mode;
        logic [1:0]       lane;
        logic [1:0]       dir;
        logic             use_ds;
        logic [ACK_W-1:0] ack_code;
        logic [1:0]       space;
        logic [2:0]       level;
        logic             avec;
    } opt_t;

endpackage

// File: rtl/csel_regs.sv
module csel_regs
    import csel_pkg::*;
#(
    parameter int BASE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [15:0]       cfg_wdata,
    output logic [BASE_W-1:0] base_q,
    output opt_t              opt_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            opt_q  <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) opt_q  <= opt_t'(cfg_wdata);
            else         base_q <= cfg_wdata[15 -: BASE_W];
        end
    end

endmodule

// File: rtl/csel_match.sv
module csel_match #(
    parameter int ADDR_W = 24,
    parameter int BASE_W = 13,
    parameter bit PORT16 = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        fc,
    input  logic              rw,
    input  logic [1:0]        siz,
    input  logic [BASE_W-1:0] base,
    input  logic [1:0]        space,
    input  logic [1:0]        dir,
    input  logic [1:0]        lane,
    input  logic [2:0]        level,
    output logic              hit,
    output logic              cpu_space
);

    localparam int MID_HI = ADDR_W - BASE_W - 1;

    logic is_user, is_sup;
    logic space_ok, addr_ok, dir_ok, lane_ok, level_ok;
    logic unused_mid;

    assign unused_mid = ^addr[MID_HI:4];

    assign cpu_space = (fc == 3'b111);
    assign is_user   = (fc == 3'd1) || (fc == 3'd2);
    assign is_sup    = (fc == 3'd5) || (fc == 3'd6);
    assign level_ok  = (level == 3'b000) || (addr[3:1] == level);

    always_comb begin
        unique case (space)
            2'b00:   space_ok = cpu_space;
            2'b01:   space_ok = is_user;
            2'b10:   space_ok = is_sup;
            default: space_ok = is_user || is_sup;
        endcase
    end

    assign addr_ok = cpu_space ? level_ok
                               : (addr[ADDR_W-1 -: BASE_W] == base);

    always_comb begin
        unique case (dir)
            2'b00:   dir_ok = 1'b0;
            2'b01:   dir_ok = rw;
            2'b10:   dir_ok = !rw;
            default: dir_ok = 1'b1;
        endcase
    end

    generate
        if (PORT16) begin : g_lane
            logic multi, hi_lane, lo_lane;
            assign multi   = (siz != 2'b01);
            assign hi_lane = multi || !addr[0];
            assign lo_lane = multi ||  addr[0];
            always_comb begin
                unique case (lane)
                    2'b00:   lane_ok = 1'b0;
                    2'b01:   lane_ok = lo_lane;
                    2'b10:   lane_ok = hi_lane;
                    default: lane_ok = 1'b1;
                endcase
            end
        end else begin : g_nolane
            logic unused_lane;
            assign unused_lane = ^{lane, siz, addr[0]};
            assign lane_ok = 1'b1;
        end
    endgenerate

    assign hit = space_ok && addr_ok && dir_ok && lane_ok;

endmodule

// File: rtl/csel_fsm.sv
module csel_fsm
    import csel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             as_n,
    input  logic             ds_n,
    input  logic             eclk_en,
    input  logic             hit,
    input  logic             sync_mode,
    input  logic             use_ds,
    input  logic [ACK_W-1:0] ack_code,
    output logic             cs_act,
    output logic             ack_act
);

    cs_state_e        state_q, state_d;
    logic [ACK_W-1:0] cnt_q;
    logic             strobe, launch;
    cs_state_e        launch_st;

    assign strobe = !as_n && (use_ds ? !ds_n : 1'b1);

    always_comb begin
        if (ack_code == ACK_EXT)
            launch_st = ST_EXT;
        else if (ack_code == ACK_FAST || ack_code == '0)
            launch_st = ST_ACK;
        else
            launch_st = ST_WAIT;
    end

    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        if (as_n) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (strobe) begin
                        if (!hit) begin
                            state_d = ST_MISS;
                        end else if (sync_mode && !eclk_en) begin
                            state_d = ST_SYNC;
                        end else begin
                            launch  = 1'b1;
                            state_d = launch_st;
                        end
                    end
                end
                ST_SYNC: begin
                    if (eclk_en) begin
                        launch  = 1'b1;
                        state_d = launch_st;
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == ACK_W'(1)) state_d = ST_ACK;
                end
                ST_ACK, ST_EXT, ST_MISS: state_d = state_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (launch)
                cnt_q <= ack_code;
            else if (state_q == ST_WAIT)
                cnt_q <= cnt_q - ACK_W'(1);
        end
    end

    always_comb begin
        logic direct;
        direct  = (state_q == ST_IDLE) && strobe && hit && !sync_mode;
        cs_act  = 1'b0;
        ack_act = 1'b0;
        if (rst_n && !as_n) begin
            unique case (state_q)
                ST_WAIT, ST_EXT: cs_act = 1'b1;
                ST_ACK: begin
                    cs_act  = 1'b1;
                    ack_act = 1'b1;
                end
                ST_IDLE: begin
                    cs_act  = direct;
                    ack_act = direct && (ack_code == ACK_FAST);
                end
                default: begin
                    cs_act  = 1'b0;
                    ack_act = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/csel_channel.sv
module csel_channel
    import csel_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BASE_W = 13,
    parameter bit PORT16 = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [15:0]       cfg_wdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_fc,
    input  logic              bus_rw,
    input  logic [1:0]        bus_siz,
    input  logic              bus_as_n,
    input  logic              bus_ds_n,
    input  logic              eclk_en,
    input  logic              irq_pin_ack,
    output logic              cs_n,
    output logic              int_ack_n,
    output logic              avec_req
);

    logic [BASE_W-1:0] base_q;
    opt_t              opt_q;
    logic              hit, cpu_space, cs_act, ack_act;

    csel_regs #(.BASE_W(BASE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_q),
        .opt_q     (opt_q)
    );

    csel_match #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .PORT16(PORT16)) u_match (
        .addr      (bus_addr),
        .fc        (bus_fc),
        .rw        (bus_rw),
        .siz       (bus_siz),
        .base      (base_q),
        .space     (opt_q.space),
        .dir       (opt_q.dir),
        .lane      (opt_q.lane),
        .level     (opt_q.level),
        .hit       (hit),
        .cpu_space (cpu_space)
    );

    csel_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_n      (bus_as_n),
        .ds_n      (bus_ds_n),
        .eclk_en   (eclk_en),
        .hit       (hit),
        .sync_mode (opt_q.sync_mode),
        .use_ds    (opt_q.use_ds),
        .ack_code  (opt_q.ack_code),
        .cs_act    (cs_act),
        .ack_act   (ack_act)
    );

    assign cs_n      = !cs_act;
    assign int_ack_n = !ack_act;
    assign avec_req  = cs_act && cpu_space && opt_q.avec && irq_pin_ack;

endmodule

// File: rtl/csel_channel_chk.sv
module csel_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_as_n,
    input logic cs_n,
    input logic int_ack_n,
    input logic avec_req
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (cs_n && int_ack_n && !avec_req));

    // R11
    as_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as_n |-> (cs_n && int_ack_n));

    // R13
    ack_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_ack_n |-> !cs_n);

    // R12
    avec_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avec_req |-> !cs_n);

    // R9
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_ack_n |=> (bus_as_n || !int_ack_n));

    // R10
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> (bus_as_n || !cs_n));

endmodule

bind csel_channel csel_channel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_as_n  (bus_as_n),
    .cs_n      (cs_n),
    .int_ack_n (int_ack_n),
    .avec_req  (avec_req)
);

// File: tb/sim_csel_channel.sv
`timescale 1ns/1ps
module sim_csel_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [23:0] bus_addr = '0;
    logic [2:0]  bus_fc = '0;
    logic        bus_rw = 1'b1;
    logic [1:0]  bus_siz = 2'b10;
    logic        bus_as_n = 1'b1, bus_ds_n = 1'b1;
    logic        eclk_en = 1'b0, irq_pin_ack = 1'b0;
    logic        cs_n, int_ack_n, avec_req;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    csel_channel u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .bus_fc(bus_fc),
        .bus_rw(bus_rw), .bus_siz(bus_siz), .bus_as_n(bus_as_n),
        .bus_ds_n(bus_ds_n), .eclk_en(eclk_en), .irq_pin_ack(irq_pin_ack),
        .cs_n(cs_n), .int_ack_n(int_ack_n), .avec_req(avec_req)
    );

    // {base[15:0], opt[15:0], addr[23:0], fc, rw, siz[1:0], expected select}
    localparam int NV = 24;
    localparam logic [62:0] VEC [NV] = '{
        {16'h1238, 16'h7BA0, 24'h123800, 3'd5, 1'b1, 2'b10, 1'b1}, // R2
        {16'h1238, 16'h7BA0, 24'h123FFE, 3'd5, 1'b1, 2'b10, 1'b1}, // R2
        {16'h1238, 16'h7BA0, 24'h124000, 3'd5, 1'b1, 2'b10, 1'b0}, // R2
        {16'h1238, 16'h7BA0, 24'h123800, 3'd1, 1'b1, 2'b10, 1'b0}, // R3
        {16'h1238, 16'h7B90, 24'h123800, 3'd2, 1'b1, 2'b10, 1'b1}, // R3
        {16'h1238, 16'h7B90, 24'h123800, 3'd6, 1'b1, 2'b10, 1'b0}, // R3
        {16'h1238, 16'h7BB0, 24'h123800, 3'd1, 1'b1, 2'b10, 1'b1}, // R3
        {16'h1238, 16'h7BB0, 24'h123800, 3'd6, 1'b1, 2'b10, 1'b1}, // R3
        {16'h1238, 16'h7BB0, 24'h123800, 3'd3, 1'b1, 2'b10, 1'b0}, // R3
        {16'h1238, 16'h6BA0, 24'h123800, 3'd5, 1'b0, 2'b10, 1'b0}, // R5
        {16'h1238, 16'h6BA0, 24'h123800, 3'd5, 1'b1, 2'b10, 1'b1}, // R5
        {16'h1238, 16'h73A0, 24'h123800, 3'd5, 1'b0, 2'b10, 1'b1}, // R5
        {16'h1238, 16'h73A0, 24'h123800, 3'd5, 1'b1, 2'b10, 1'b0}, // R5
        {16'h1238, 16'h63A0, 24'h123800, 3'd5, 1'b1, 2'b10, 1'b0}, // R5
        {16'h1238, 16'h5BA0, 24'h123802, 3'd5, 1'b1, 2'b01, 1'b1}, // R6
        {16'h1238, 16'h5BA0, 24'h123803, 3'd5, 1'b1, 2'b01, 1'b0}, // R6
        {16'h1238, 16'h5BA0, 24'h123803, 3'd5, 1'b1, 2'b10, 1'b1}, // R6
        {16'h1238, 16'h3BA0, 24'h123803, 3'd5, 1'b1, 2'b01, 1'b1}, // R6
        {16'h1238, 16'h3BA0, 24'h123802, 3'd5, 1'b1, 2'b01, 1'b0}, // R6
        {16'h1238, 16'h1BA0, 24'h123800, 3'd5, 1'b1, 2'b10, 1'b0}, // R6
        {16'h1238, 16'h7B8A, 24'hFFFFFA, 3'd7, 1'b1, 2'b01, 1'b1}, // R4
        {16'h1238, 16'h7B8A, 24'hFFFFF6, 3'd7, 1'b1, 2'b01, 1'b0}, // R4
        {16'h1238, 16'h7B80, 24'hFFFFF6, 3'd7, 1'b1, 2'b01, 1'b1}, // R4
        {16'h1238, 16'h7B8A, 24'h123800, 3'd5, 1'b1, 2'b10, 1'b0}  // R4
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic sel, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic start(input logic [23:0] a, input logic [2:0] f,
                         input logic r, input logic [1:0] s, input logic ds);
        @(negedge clk);
        bus_addr = a; bus_fc = f; bus_rw = r; bus_siz = s;
        bus_as_n = 1'b0; bus_ds_n = ds;
        #1;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_acc();
        @(negedge clk);
        bus_as_n = 1'b1; bus_ds_n = 1'b1;
        #1;
        chk("R11 cs on AS release", cs_n, 1'b1);
        chk("R11 ack on AS release", int_ack_n, 1'b1);
        @(negedge clk);
    endtask

    task automatic wait_test(input logic [3:0] n, input string tag);
        start(24'h123800, 3'd5, 1'b1, 2'b10, 1'b0);
        chk(tag, cs_n, 1'b0);
        for (int k = 0; k <= n + 1; k++) begin
            if (k > 0) step();
            chk(tag, int_ack_n, (k == n + 1) ? 1'b0 : 1'b1);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        // R1: outputs quiet in reset even with AS asserted
        bus_as_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 cs in reset", cs_n, 1'b1);
        chk("R1 ack in reset", int_ack_n, 1'b1);
        bus_as_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        // R1: cleared config never selects
        start(24'h000000, 3'd5, 1'b1, 2'b10, 1'b0);
        chk("R1 no select after reset", cs_n, 1'b0 ^ 1'b1);
        finish_acc();

        for (int i = 0; i < NV; i++) begin
            logic [62:0] v;
            v = VEC[i];
            cfg(1'b0, v[62:47]);
            cfg(1'b1, v[46:31]);
            start(v[30:7], v[6:4], v[3], v[2:1], 1'b0);
            chk($sformatf("R2-6 vector %0d cs", i), cs_n, !v[0]);
            chk($sformatf("R10 vector %0d fast ack", i), int_ack_n, !v[0]);
            finish_acc();
        end

        cfg(1'b0, 16'h1238);
        // R9: three waits, then counter reload on a new access (R11)
        cfg(1'b1, 16'h78E0);
        wait_test(4'd3, "R9 N=3");
        finish_acc();
        wait_test(4'd3, "R11 reload N=3");
        finish_acc();
        cfg(1'b1, 16'h7820);
        wait_test(4'd0, "R9 N=0");
        finish_acc();
        cfg(1'b1, 16'h7B60);
        wait_test(4'd13, "R9 N=13");
        finish_acc();

        // R10: external acknowledge keeps select, never acks
        cfg(1'b1, 16'h7BE0);
        start(24'h123800, 3'd5, 1'b1, 2'b10, 1'b0);
        for (int k = 0; k < 20; k++) begin
            if (k > 0) step();
            chk("R10 ext cs", cs_n, 1'b0);
            chk("R10 ext no ack", int_ack_n, 1'b1);
        end
        finish_acc();

        // R7: data-strobe select
        cfg(1'b1, 16'h7FA0);
        start(24'h123800, 3'd5, 1'b1, 2'b10, 1'b1);
        chk("R7 no cs before DS", cs_n, 1'b1);
        @(negedge clk);
        bus_ds_n = 1'b0;
        #1;
        chk("R7 cs with DS", cs_n, 1'b0);
        finish_acc();

        // R8: sync mode aligns to eclk_en
        cfg(1'b1, 16'hFBA0);
        start(24'h123800, 3'd5, 1'b1, 2'b10, 1'b0);
        chk("R8 k0 no cs", cs_n, 1'b1);
        step();
        chk("R8 k1 no cs", cs_n, 1'b1);
        @(negedge clk);
        eclk_en = 1'b1;
        #1;
        chk("R8 enable cycle no cs", cs_n, 1'b1);
        @(negedge clk);
        eclk_en = 1'b0;
        #1;
        chk("R8 cs after enable", cs_n, 1'b0);
        chk("R10 sync fast ack", int_ack_n, 1'b0);
        finish_acc();

        // R12: autovector request
        cfg(1'b1, 16'h7B81);
        irq_pin_ack = 1'b1;
        start(24'hFFFFF6, 3'd7, 1'b1, 2'b01, 1'b0);
        chk("R12 avec pin", avec_req, 1'b1);
        chk("R13 ack with cs", cs_n, 1'b0);
        irq_pin_ack = 1'b0;
        #1;
        chk("R12 avec no pin", avec_req, 1'b0);
        finish_acc();
        cfg(1'b1, 16'h7B80);
        irq_pin_ack = 1'b1;
        start(24'hFFFFF6, 3'd7, 1'b1, 2'b01, 1'b0);
        chk("R12 avec bit clear", avec_req, 1'b0);
        finish_acc();

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule